// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Block

This block belongs to a single CPU core and gathers interrupt requests that other cores post to it. Software reaches it through a simple 32-bit register bus. The bus gives access to a read-only pending word, an enable mask, a write-one-to-set port, a write-one-to-clear port and eight 32-bit mailbox words. Cores use the mailbox words to pass small messages alongside the interrupt. The block drives one level interrupt line towards its core.

The interrupt line is a register, not a continuous function of pending and enable. A set write can raise it. A clear write can lower it. Each of the two writes tests its own condition. A write to the enable mask only stores the mask and leaves the line alone, so software must follow a mask change with a set or clear write when it needs the line brought up to date. Only the low eight address bits are decoded. An access to any offset that decodes to nothing is harmless and raises a one-cycle error flag.

Top module: `xcore_irq_regs`

## Requirements
- R1: Only address bits [7:0] select a register. The upper address bits have no effect on decode.
- R2: A write to offset 0x04 stores the written value as the enable mask, which reads back at 0x04. This write never changes irq_out.
- R3: A write to offset 0x08 ORs the written value into the pending word. irq_out becomes 1 when (new pending AND enable) is nonzero. Otherwise irq_out keeps its value.
- R4: A write to offset 0x0C clears the pending bits where the written value has ones. irq_out becomes 0 only when the new pending word is zero and the enable mask is nonzero. Otherwise irq_out keeps its value, even when no enabled bit is left pending.
- R5: Reads of offsets 0x08 and 0x0C return zero. The pending word reads at offset 0x00, and a write to offset 0x00 changes neither the pending word nor irq_out.
- R6: Eight mailbox words are readable and writable at offsets 0x20 through 0x3C. The word index is (offset − 0x20) >> 2, so unaligned offsets inside that range select the enclosing word.
- R7: Read data appears on bus_rdata in the cycle after bus_rd is sampled and shows the state from before any write in the same cycle. At other times bus_rdata is zero.
- R8: An access to any other offset (for example 0x10, 0x40, 0x3D or 0x44) reads zero and changes no state. It sets bus_err to 1 for exactly the following cycle.
- R9: A synchronous active-high reset clears the pending word, the enable mask, every mailbox word, irq_out, bus_rdata and bus_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address; only bits [7:0] are decoded |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| bus_err | output | 1 | One-cycle pulse after an access to an undecoded offset |
| irq_out | output | 1 | Level interrupt request to the core |

## Verification
The hardest states to reach are the ones where irq_out disagrees with (pending AND enable). In one such state the line stays high after clear writes because the mask was zeroed first. In another a clear write leaves only masked bits pending, so the line stays high. In a third a set write lands only on masked bits, so the line stays low. The stimulus reaches these states on purpose with ordered sequences of mask writes, set writes and clear writes. The bench keeps a reference model built from the requirements and compares against it after every access, so each stale line level is checked when it occurs.

// File: rtl/xcore_irq_pkg.sv
package xcore_irq_pkg;

    localparam int DATA_W = 32;

    // Fixed register offsets inside the low address byte
    localparam logic [7:0] OFF_PEND  = 8'h00;
    localparam logic [7:0] OFF_MASK  = 8'h04;
    localparam logic [7:0] OFF_SET   = 8'h08;
    localparam logic [7:0] OFF_CLR   = 8'h0C;
    localparam logic [7:0] OFF_MBOX  = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_MASK,
        SEL_SET,
        SEL_CLR,
        SEL_MBOX
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] mask;
        logic              irq;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } ctl_state_t;

endpackage

// File: rtl/xcore_irq_decode.sv
module xcore_irq_decode
    import xcore_irq_pkg::*;
#(
    parameter int MBOX_WORDS = 8,
    localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
    input  logic [7:0]       offset,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] mbox_idx
);

    localparam logic [7:0] MBOX_LAST = OFF_MBOX + 8'(4 * (MBOX_WORDS - 1));

    logic [7:0] rel;

    always_comb begin
        rel      = offset - OFF_MBOX;
        mbox_idx = rel[IDX_W+1:2];
        if (offset >= OFF_MBOX && offset <= MBOX_LAST) begin
            sel = SEL_MBOX;
        end else begin
            case (offset)
                OFF_PEND: sel = SEL_PEND;
                OFF_MASK: sel = SEL_MASK;
                OFF_SET:  sel = SEL_SET;
                OFF_CLR:  sel = SEL_CLR;
                default:  sel = SEL_NONE;
            endcase
        end
    end

    logic unused_rel;
    assign unused_rel = ^{rel[7:IDX_W+2], rel[1:0]};

endmodule

// File: rtl/xcore_irq_mbox.sv
module xcore_irq_mbox
    import xcore_irq_pkg::*;
#(
    parameter int MBOX_WORDS = 8,
    localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] word_q [MBOX_WORDS];

    for (genvar g = 0; g < MBOX_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_d;

        always_comb begin
            word_d = word_q[g];
            if (wr_en && idx == IDX_W'(g)) begin
                word_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[g] <= '0;
            end else begin
                word_q[g] <= word_d;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < MBOX_WORDS; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_word = word_q[i];
            end
        end
    end

endmodule

// File: rtl/xcore_irq_regs.sv
module xcore_irq_regs
    import xcore_irq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MBOX_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              irq_out
);

    localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;

    reg_sel_e          sel;
    logic [IDX_W-1:0]  mbox_idx;
    logic              mbox_we;
    logic [DATA_W-1:0] mbox_word;
    ctl_state_t        state_d;
    ctl_state_t        state_q;

    xcore_irq_decode #(.MBOX_WORDS(MBOX_WORDS)) u_decode (
        .offset   (bus_addr[7:0]),
        .sel      (sel),
        .mbox_idx (mbox_idx)
    );

    xcore_irq_mbox #(.MBOX_WORDS(MBOX_WORDS)) u_mbox (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mbox_we),
        .idx     (mbox_idx),
        .wdata   (bus_wdata),
        .rd_word (mbox_word)
    );

    always_comb begin
        state_d       = state_q;
        state_d.rdata = '0;
        state_d.err   = 1'b0;
        mbox_we       = 1'b0;

        // Reads show the state held before this cycle's write
        if (bus_rd) begin
            case (sel)
                SEL_PEND: state_d.rdata = state_q.pend;
                SEL_MASK: state_d.rdata = state_q.mask;
                SEL_MBOX: state_d.rdata = mbox_word;
                default:  state_d.rdata = '0;
            endcase
        end

        if (bus_wr) begin
            case (sel)
                SEL_MASK: state_d.mask = bus_wdata;
                SEL_SET: begin
                    state_d.pend = state_q.pend | bus_wdata;
                    if ((state_d.pend & state_q.mask) != '0) begin
                        state_d.irq = 1'b1;
                    end
                end
                SEL_CLR: begin
                    state_d.pend = state_q.pend & ~bus_wdata;
                    if (state_d.pend == '0 && state_q.mask != '0) begin
                        state_d.irq = 1'b0;
                    end
                end
                SEL_MBOX: mbox_we = 1'b1;
                default: ;
            endcase
        end

        if ((bus_rd || bus_wr) && sel == SEL_NONE) begin
            state_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;
    assign bus_err   = state_q.err;
    assign irq_out   = state_q.irq;

    logic unused_addr_hi;
    assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];

endmodule

// File: rtl/xcore_irq_chk.sv
module xcore_irq_chk #(
    parameter int ADDR_W     = 16,
    parameter int MBOX_WORDS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              irq_out
);

    logic [7:0] off;
    logic       known;
    assign off   = bus_addr[7:0];
    assign known = (off == 8'h00) || (off == 8'h04) || (off == 8'h08) ||
                   (off == 8'h0C) ||
                   (off >= 8'h20 && off <= 8'(8'h20 + 4 * (MBOX_WORDS - 1)));

    logic unused_hi;
    assign unused_hi = ^bus_addr[ADDR_W-1:8];

    assert_rise_on_set_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(bus_wr && off == 8'h08));

    assert_fall_on_clear_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_out) |-> $past(bus_wr && off == 8'h0C));

    assert_mask_keeps_line_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && off == 8'h04) |=> $stable(irq_out));

    assert_port_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (off == 8'h08 || off == 8'h0C)) |=> (bus_rdata == 32'h0));

    assert_err_on_unknown_R8: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && !known) |=> bus_err);

    assert_err_only_unknown_R8: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past((bus_rd || bus_wr) && !known));

    assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 32'h0));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (!irq_out && !bus_err && bus_rdata == 32'h0));

endmodule

bind xcore_irq_regs xcore_irq_chk #(.ADDR_W(ADDR_W), .MBOX_WORDS(MBOX_WORDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .irq_out   (irq_out)
);

// File: tb/xcore_irq_regs_test.sv
`timescale 1ns/1ps
module xcore_irq_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_out;

    always #5 clk = ~clk;

    xcore_irq_regs uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .irq_out   (irq_out)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference model built from the requirements
    logic [31:0] m_pend = '0;
    logic [31:0] m_mask = '0;
    logic        m_irq  = 1'b0;
    logic [31:0] m_mbox [8];

    // Scoreboard
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_issued = 1'b0;

    always @(posedge clk) rd_issued <= bus_rd;

    always @(negedge clk) begin
        if (rd_issued) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R7 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    function automatic bit is_known(input logic [7:0] off);
        return (off == 8'h00 || off == 8'h04 || off == 8'h08 || off == 8'h0C ||
                (off >= 8'h20 && off <= 8'h3C));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic post_checks(input string tag, input logic [7:0] off);
        check({tag, " err"}, {31'b0, bus_err}, {31'b0, !is_known(off)});
        check({tag, " irq"}, {31'b0, irq_out}, {31'b0, m_irq});
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
        logic [7:0] off;
        off = a[7:0];
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (off)
            8'h04: m_mask = d;
            8'h08: begin
                m_pend = m_pend | d;
                if ((m_pend & m_mask) != 0) m_irq = 1'b1;
            end
            8'h0C: begin
                m_pend = m_pend & ~d;
                if (m_pend == 0 && m_mask != 0) m_irq = 1'b0;
            end
            default: if (off >= 8'h20 && off <= 8'h3C) m_mbox[(off - 8'h20) >> 2] = d;
        endcase
        post_checks(tag, off);
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        logic [7:0] off;
        logic [31:0] e;
        off = a[7:0];
        case (off)
            8'h00:   e = m_pend;
            8'h04:   e = m_mask;
            default: e = (off >= 8'h20 && off <= 8'h3C) ? m_mbox[(off - 8'h20) >> 2] : 32'h0;
        endcase
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        post_checks(tag, off);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_mbox[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 irq after reset", {31'b0, irq_out}, 32'h0);
        check("R9 err after reset", {31'b0, bus_err}, 32'h0);
        rd(16'h0000, "R9 pend");
        rd(16'h0004, "R9 mask");
        for (int i = 0; i < 8; i++) rd(16'(32 + 4 * i), "R9 mbox");

        // R2 mask store and readback
        wr(16'h0004, 32'h0000_0005, "R2 mask write");
        rd(16'h0004, "R2 mask read");
        // R3 set on masked bit only: line stays low
        wr(16'h0008, 32'h0000_0002, "R3 set masked");
        rd(16'h0000, "R3 pend");
        // R3 set enabled bit: line rises
        wr(16'h0008, 32'h0000_0004, "R3 set enabled");
        rd(16'h0000, "R3 pend or");
        // R2 clearing mask keeps the line high
        wr(16'h0004, 32'h0000_0000, "R2 mask zero");
        // R4 clear all with mask zero: line stays high
        wr(16'h000C, 32'h0000_0006, "R4 clear mask zero");
        rd(16'h0000, "R4 pend empty");
        // R4 clear to zero with mask set: line falls
        wr(16'h0004, 32'h0000_0001, "R2 mask one");
        wr(16'h0008, 32'h0000_0001, "R3 set bit0");
        wr(16'h000C, 32'h0000_0001, "R4 clear to zero");
        // R4 partial clear leaves masked bit: line stays high
        wr(16'h0008, 32'h0000_0003, "R3 set two");
        wr(16'h000C, 32'h0000_0001, "R4 partial clear");
        rd(16'h0000, "R4 pend left");
        wr(16'h000C, 32'h0000_0002, "R4 final clear");

        // R5 set/clear ports read zero, pend write ignored
        wr(16'h0008, 32'h8000_0000, "R5 set high bit");
        rd(16'h0008, "R5 set reads zero");
        rd(16'h000C, "R5 clear reads zero");
        wr(16'h0000, 32'hFFFF_FFFF, "R5 pend write");
        rd(16'h0000, "R5 pend unchanged");

        // R6 mailbox
        for (int i = 0; i < 8; i++) wr(16'(32 + 4 * i), 32'hA5A5_0000 + 32'(i * 16'h1111), "R6 mbox write");
        for (int i = 0; i < 8; i++) rd(16'(32 + 4 * i), "R6 mbox read");
        wr(16'h0025, 32'h1234_5678, "R6 unaligned write");
        rd(16'h0024, "R6 word1");
        rd(16'h003F, "R8 0x3F outside mailbox");

        // R1 upper address bits ignored
        wr(16'hAB04, 32'h0000_00F0, "R1 high bits mask");
        rd(16'h5504, "R1 read via alias");
        rd(16'hFF3C, "R1 mailbox alias");

        // R8 undecoded offsets
        wr(16'h0010, 32'hFFFF_FFFF, "R8 write 0x10");
        wr(16'h0044, 32'hFFFF_FFFF, "R8 write 0x44");
        rd(16'h0040, "R8 read 0x40");
        rd(16'h003D, "R8 read 0x3D");
        check("R8 err one cycle", {31'b0, bus_err}, 32'h1);
        @(negedge clk);
        check("R8 err dropped", {31'b0, bus_err}, 32'h0);
        rd(16'h0000, "R8 pend intact");
        rd(16'h0004, "R8 mask intact");
        for (int i = 0; i < 8; i++) rd(16'(32 + 4 * i), "R8 mbox intact");

        // R7 idle rdata returns to zero
        @(negedge clk);
        check("R7 idle rdata", bus_rdata, 32'h0);

        // R9 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_pend = '0; m_mask = '0; m_irq = 1'b0;
        for (int i = 0; i < 8; i++) m_mbox[i] = '0;
        check("R9 irq after second reset", {31'b0, irq_out}, 32'h0);
        rd(16'h0000, "R9 pend cleared");
        rd(16'h0004, "R9 mask cleared");
        rd(16'h0024, "R9 mbox cleared");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R7 pending reads actual=%0d expected=0", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule